// File: doc/BRIEF.md
# Low-power real-time counter with seconds alarm

This block keeps time from a 32.768 kHz slow clock and presents it through 32-bit registers on a fast bus clock. It holds a 47-bit counter, treated as a fixed-point number: the upper 32 bits are whole seconds and the lower 15 bits count slow ticks within the current second. A 32-bit alarm value is compared against the seconds part. A match sets a sticky status flag, which can drive an interrupt output and a wakeup output.

The slow clock is an asynchronous input. It is sampled in the bus domain, and every rising edge produces a one-cycle step pulse. Everything that belongs to the slow domain advances only on that pulse. Software writes the control bits in the bus domain. They reach the counter and alarm logic through a two-step pipeline that moves on slow edges. The run bit comes back to the control register through a two-flop bus-side synchroniser, so software can poll it to see that a change has taken effect. The register port is plain control access rather than a data stream: writes are single cycle, reads are combinational from the address, and the port never stalls.

Top module: `lp_rtc`

## Requirements
- R1: The 47-bit counter advances by one on each acted-upon slow edge while the effective run bit is set, and holds otherwise. A carry out of the 15-bit fraction increments the seconds. The counter wraps from all ones to zero.
- R2: Offset 0x20 reads counter bits 31:0. Offset 0x1C reads counter bits 46:32 in bits 14:0, with the upper bits zero. A write to either offset loads those bits only when both the written run bit and its read-back are 0. Otherwise the write is ignored.
- R3: The control register is at offset 0x04. Bit 0 is counter run, bit 1 is alarm enable and bit 3 is wakeup enable. Bits 1 and 3 read back as written, and all other bits read 0.
- R4: A control write takes effect at the second acted-upon slow edge after it, which is within 3 slow cycles. Control bit 0 reads the effective run bit delayed by two bus cycles.
- R5: The alarm register at offset 0x24 holds 32 bits. While the effective alarm enable is set and the seconds equal the alarm value, the status flag is 1 from the next bus cycle on.
- R6: Status bit 0 at offset 0x18 is sticky. Writing 1 to it clears it, unless the alarm match holds in that cycle, in which case setting wins. Writing 0 to it has no effect.
- R7: `irq_o` is high exactly when the status flag, the effective alarm enable and the effective wakeup enable are all set.
- R8: `wake_o` is high exactly when the status flag and the effective wakeup enable are both set.
- R9: Offset 0x30 is a 32-bit storage register, for example for the guard word 0x41736166. It reads back what was written and affects nothing else.
- R10: Reset clears the counter, the control bits, the alarm, the storage word and the status flag. Unmapped offsets read 0.
- R11: `slow_clk` is sampled on every bus edge. A rising edge first sampled at bus edge n advances the slow-domain state at bus edge n+2. Each level of `slow_clk` must last at least two bus cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | 32.768 kHz timing clock, asynchronous |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
Results fall due at different times:

| Result | When it is due |
|--------|----------------|
| Register writes | Visible in the read data one bus cycle after the write edge. |
| Counter step | At the second bus edge after a slow rising edge is first sampled. |
| Control change | Takes effect at the second such step after the write. |
| Run read-back | Follows the effective run bit two bus cycles later. |
| Alarm flag | Rises one cycle after the match starts. |
| `irq_o`, `wake_o` | Follow the flag and the effective enables in the same cycle. |

The bench steps a behavioural model at every bus edge with the same sampled inputs. It drives `slow_clk` itself from a bus-cycle phase, so every step pulse falls in a known cycle. It compares the read data and both outputs 2 ns after every edge, which leaves each register on the path time to settle. Directed checks then poll the run read-back with a cycle bound, and probe the set-over-clear priority and the counter wrap.

// File: rtl/lp_rtc_pkg.sv
package lp_rtc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h04;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h18;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 8'h1C;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 8'h20;
  localparam logic [ADDR_W-1:0] A_ALARM  = 8'h24;
  localparam logic [ADDR_W-1:0] A_GUARD  = 8'h30;

  localparam int B_RUN  = 0;
  localparam int B_ALM  = 1;
  localparam int B_WAKE = 3;

  typedef struct packed {
    logic wake;
    logic alm;
    logic run;
  } ctl_t;
endpackage

// File: rtl/lp_rtc_tick.sv
module lp_rtc_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic tick
);
  logic [2:0] smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[1:0], slow_clk};
  end

  assign tick = smp[1] & ~smp[2];

  // R11: one step per slow rising edge, never two adjacent
  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/lp_rtc_ctlsync.sv
module lp_rtc_ctlsync
  import lp_rtc_pkg::*;
#(
  parameter int STAGES = 2,
  parameter int RB_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  ctl_t ctl_sw,
  output ctl_t ctl_eff,
  output logic run_seen
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    ctl_t q;
    ctl_t d;
    if (i == 0) begin : g_first
      assign d = ctl_sw;
    end else begin : g_next
      assign d = g_stg[i-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (tick) q <= d;
    end
  end

  assign ctl_eff = g_stg[STAGES-1].q;

  logic [RB_STAGES-1:0] rb;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb <= '0;
    else        rb <= {rb[RB_STAGES-2:0], ctl_eff.run};
  end
  assign run_seen = rb[RB_STAGES-1];

  // R4: effective control moves only on a slow step
  assert_eff_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ctl_eff));
  // R4: read-back trails the effective run bit by two bus cycles
  assert_rb_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_seen == $past(ctl_eff.run, 2));
endmodule

// File: rtl/lp_rtc_counter.sv
module lp_rtc_counter
  import lp_rtc_pkg::*;
#(
  parameter int CNT_W = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [DATA_W-1:0] ld_data,
  output logic [CNT_W-1:0]  cnt
);
  localparam int HI_W = CNT_W - DATA_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld_hi || ld_lo) begin
      if (ld_hi) cnt[CNT_W-1:DATA_W] <= ld_data[HI_W-1:0];
      if (ld_lo) cnt[DATA_W-1:0]     <= ld_data;
    end else if (tick && run) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R1: one step per acted-upon slow edge while running
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !ld_hi && !ld_lo) |=> cnt == $past(cnt) + 1'b1);
  // R1: no step without a slow edge or a load
  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_hi && !ld_lo) |=> $stable(cnt));
endmodule

// File: rtl/lp_rtc_alarm.sv
module lp_rtc_alarm #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] secs,
  input  logic [SEC_W-1:0] alarm,
  input  logic             alm_en,
  input  logic             clr,
  output logic             flag
);
  logic hit;
  assign hit = alm_en && (secs == alarm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= hit | (flag & ~clr);
  end

  // R6: the flag stays set until a clear arrives
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R5: a match with the alarm enabled sets the flag next cycle
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_en && secs == alarm) |=> flag);
endmodule

// File: rtl/lp_rtc.sv
module lp_rtc
  import lp_rtc_pkg::*;
#(
  parameter int CNT_W       = 47,
  parameter int FRAC_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int SEC_W = CNT_W - FRAC_W;
  localparam int HI_W  = CNT_W - DATA_W;

  logic              tick;
  ctl_t              ctl_sw;
  ctl_t              ctl_eff;
  logic              run_seen;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] alarm_q;
  logic [DATA_W-1:0] guard_q;
  logic              flag;

  logic wr_ctrl, wr_stat, wr_hi, wr_lo, wr_alarm, wr_guard, load_ok;
  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_stat  = bus_we && (bus_addr == A_STAT);
  assign wr_hi    = bus_we && (bus_addr == A_CNT_HI);
  assign wr_lo    = bus_we && (bus_addr == A_CNT_LO);
  assign wr_alarm = bus_we && (bus_addr == A_ALARM);
  assign wr_guard = bus_we && (bus_addr == A_GUARD);
  assign load_ok  = !ctl_sw.run && !run_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_sw  <= '0;
      alarm_q <= '0;
      guard_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctl_sw.run  <= bus_wdata[B_RUN];
        ctl_sw.alm  <= bus_wdata[B_ALM];
        ctl_sw.wake <= bus_wdata[B_WAKE];
      end
      if (wr_alarm) alarm_q <= bus_wdata;
      if (wr_guard) guard_q <= bus_wdata;
    end
  end

  lp_rtc_tick u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_clk (slow_clk),
    .tick     (tick)
  );

  lp_rtc_ctlsync #(.STAGES(SYNC_STAGES), .RB_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ctl_sw   (ctl_sw),
    .ctl_eff  (ctl_eff),
    .run_seen (run_seen)
  );

  lp_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (ctl_eff.run),
    .ld_hi   (wr_hi && load_ok),
    .ld_lo   (wr_lo && load_ok),
    .ld_data (bus_wdata),
    .cnt     (cnt)
  );

  lp_rtc_alarm #(.SEC_W(SEC_W)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .secs   (cnt[CNT_W-1:FRAC_W]),
    .alarm  (alarm_q[SEC_W-1:0]),
    .alm_en (ctl_eff.alm),
    .clr    (wr_stat && bus_wdata[0]),
    .flag   (flag)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[B_RUN]  = run_seen;
        bus_rdata[B_ALM]  = ctl_sw.alm;
        bus_rdata[B_WAKE] = ctl_sw.wake;
      end
      A_STAT:   bus_rdata[0] = flag;
      A_CNT_HI: bus_rdata[HI_W-1:0] = cnt[CNT_W-1:DATA_W];
      A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
      A_ALARM:  bus_rdata = alarm_q;
      A_GUARD:  bus_rdata = guard_q;
      default:  ;
    endcase
  end

  assign irq_o  = flag & ctl_eff.alm & ctl_eff.wake;
  assign wake_o = flag & ctl_eff.wake;

  // R7: an interrupt always comes with a wakeup request
  assert_irq_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> wake_o);
  // R2: a load while the run read-back is set leaves the count alone
  assert_load_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lo || wr_hi) && run_seen && !tick) |=> $stable(cnt));
endmodule

// File: tb/lp_rtc_bench.sv
module lp_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_o, wake_o;

  int tests = 0;
  int fails = 0;
  bit slow_on = 1'b0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;
  int ph = 0;

  always #4 clk = ~clk;

  lp_rtc u_lp_rtc (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  // slow clock: two bus cycles high, two low (R11)
  always @(negedge clk) if (slow_on) begin
    ph = ph + 1;
    slow_clk = ph[1];
  end

  // behavioural model, stepped on each bus edge
  bit [46:0] m_cnt;
  bit [2:0]  m_sw, m_e1, m_e2;   // {wake, alm, run}
  bit        m_rb1, m_rb2, m_flag;
  bit [31:0] m_alarm, m_guard;
  bit [2:0]  m_h;

  always @(posedge clk) begin
    bit tk, hit, clr, ld_ok;
    if (!rst_n) begin
      m_cnt = '0; m_sw = '0; m_e1 = '0; m_e2 = '0;
      m_rb1 = 0; m_rb2 = 0; m_flag = 0; m_alarm = '0; m_guard = '0; m_h = '0;
    end else begin
      tk    = m_h[1] & ~m_h[2];
      m_h   = {m_h[1:0], slow_clk};
      hit   = m_e2[1] && (m_cnt[46:15] == m_alarm);
      clr   = bus_we && bus_addr == 8'h18 && bus_wdata[0];
      ld_ok = !m_sw[0] && !m_rb2;
      m_flag = hit | (m_flag & ~clr);
      if (bus_we && ld_ok && (bus_addr == 8'h1C || bus_addr == 8'h20)) begin
        if (bus_addr == 8'h1C) m_cnt[46:32] = bus_wdata[14:0];
        else                   m_cnt[31:0]  = bus_wdata;
      end else if (tk && m_e2[0]) begin
        m_cnt = m_cnt + 47'd1;
      end
      m_rb2 = m_rb1;
      m_rb1 = m_e2[0];
      if (tk) begin
        m_e2 = m_e1;
        m_e1 = m_sw;
      end
      if (bus_we && bus_addr == 8'h04) m_sw = {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
      if (bus_we && bus_addr == 8'h24) m_alarm = bus_wdata;
      if (bus_we && bus_addr == 8'h30) m_guard = bus_wdata;
    end
  end

  function automatic bit [31:0] exp_rd(input bit [7:0] a);
    case (a)
      8'h04: return {28'd0, m_sw[2], 1'b0, m_sw[1], m_rb2};
      8'h18: return {31'd0, m_flag};
      8'h1C: return {17'd0, m_cnt[46:32]};
      8'h20: return m_cnt[31:0];
      8'h24: return m_alarm;
      8'h30: return m_guard;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input bit [7:0] a);
    case (a)
      8'h04: return "R3/R4";
      8'h18: return "R6";
      8'h1C, 8'h20: return "R1/R2";
      8'h24: return "R5";
      8'h30: return "R9";
      default: return "R10";
    endcase
  endfunction

  // per-edge comparison, 2 ns after the edge
  always @(posedge clk) begin
    #2;
    if (cmp_on && !done) begin
      tests++;
      if (bus_rdata !== exp_rd(bus_addr)) begin
        fails++;
        $display("FAIL %s addr %h: actual %h expected %h at %0t",
                 tag_of(bus_addr), bus_addr, bus_rdata, exp_rd(bus_addr), $time);
      end
      tests++;
      if (irq_o !== (m_flag & m_e2[1] & m_e2[2])) begin
        fails++;
        $display("FAIL R7 irq: actual %b expected %b at %0t", irq_o,
                 m_flag & m_e2[1] & m_e2[2], $time);
      end
      tests++;
      if (wake_o !== (m_flag & m_e2[2])) begin
        fails++;
        $display("FAIL R8 wake: actual %b expected %b at %0t", wake_o,
                 m_flag & m_e2[2], $time);
      end
    end
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input bit [7:0] a, output bit [31:0] v);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #2;
    v = bus_rdata;
  endtask

  task automatic wait_run(input bit v, input string tag);
    bit [31:0] r;
    int n = 0;
    r = 32'd0;
    for (int i = 0; i < 64; i++) begin
      rd(8'h04, r);
      n++;
      if (r[0] == v) break;
    end
    // R4: read-back settles within 3 slow cycles plus the bus-side delay
    chk(tag, {31'd0, (r[0] == v) && (n <= 16)}, 32'd1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    bit [31:0] r, r2;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    rst_n = 1'b1;
    slow_on = 1'b1;
    // R10: everything reads zero after reset
    rd(8'h04, r); chk("R10 ctrl", r, 32'd0);
    rd(8'h20, r); chk("R10 count lo", r, 32'd0);
    rd(8'h18, r); chk("R10 status", r, 32'd0);
    rd(8'h08, r); chk("R10 unmapped", r, 32'd0);
    // R9: storage word
    wr(8'h30, 32'h41736166);
    rd(8'h30, r); chk("R9 guard", r, 32'h41736166);
    rd(8'h20, r); chk("R9 no side effect", r, 32'd0);
    // R2: load seconds 5, fraction near carry
    wr(8'h1C, 32'h0);
    wr(8'h20, (32'd5 << 15) | 32'h7FF8);
    rd(8'h20, r); chk("R2 load lo", r, (32'd5 << 15) | 32'h7FF8);
    // R3: enable bits read back
    wr(8'h24, 32'd6);
    wr(8'h04, 32'h0000_00FB);
    rd(8'h04, r); chk("R3 ctrl bits", r & 32'hA, 32'hA);
    wait_run(1'b1, "R4 run read-back");
    // R1/R5: carry into second 6 raises the flag and the interrupt
    idle(48);
    rd(8'h1C, r); chk("R1 hi", r, 32'd0);
    rd(8'h20, r); chk("R1 seconds carry", r >> 15, 32'd6);
    rd(8'h18, r); chk("R5 flag", r, 32'd1);
    chk("R7 irq", {31'd0, irq_o}, 32'd1);
    // R2: load ignored while running
    wr(8'h20, 32'd0);
    rd(8'h20, r); chk("R2 ignored", r >> 15, 32'd6);
    // R6: clear loses to a live match
    wr(8'h18, 32'd1);
    rd(8'h18, r); chk("R6 set wins", r, 32'd1);
    wr(8'h24, 32'd100);
    wr(8'h18, 32'd0);
    rd(8'h18, r); chk("R6 write 0 keeps", r, 32'd1);
    wr(8'h18, 32'd1);
    rd(8'h18, r); chk("R6 cleared", r, 32'd0);
    chk("R7 irq off", {31'd0, irq_o}, 32'd0);
    // R8: flag without wakeup enable
    wr(8'h04, 32'h3);
    idle(16);
    wr(8'h24, 32'd6);
    idle(4);
    chk("R8 wake off", {31'd0, wake_o}, 32'd0);
    chk("R7 irq needs wake", {31'd0, irq_o}, 32'd0);
    wr(8'h04, 32'h9);
    idle(16);
    chk("R8 wake on", {31'd0, wake_o}, 32'd1);
    chk("R7 irq needs alarm", {31'd0, irq_o}, 32'd0);
    // R1: wrap from all ones
    wr(8'h04, 32'h0);
    wait_run(1'b0, "R4 stop read-back");
    wr(8'h1C, 32'h7FFF);
    wr(8'h20, 32'hFFFF_FFFD);
    wr(8'h04, 32'h1);
    idle(40);
    rd(8'h1C, r); chk("R1 wrap hi", r, 32'd0);
    // R1: disabled counter holds
    wr(8'h04, 32'h0);
    wait_run(1'b0, "R4 stop again");
    idle(8);
    rd(8'h20, r);
    idle(40);
    rd(8'h20, r2); chk("R1 hold", r2, r);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1'b1;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule